// File: doc/BRIEF.md
# Bit-Serial Distributed-Arithmetic FIR Filter

This block is an eight-tap FIR filter that uses no multipliers. Each accepted 16-bit sample enters a delay line of tap registers. During the following 16 cycles, every tap register rotates by one bit per cycle. The current bit of each tap forms part of an address into small tables. Each table holds, for every subset of its group of taps, the sum of that subset's coefficients. The table words are added together and folded into an accumulator. The accumulator shifts right by one place per bit, so each bit position gets its binary weight. On the sign-bit cycle the table sum is subtracted, which makes the result exact for two's-complement samples.

Software or a configuration engine fills the tables through a write port while the filter is idle. The filter itself never multiplies. It takes one new sample per frame of 16 bit cycles and returns one full-precision output word per sample, marked by a single-cycle valid pulse.

Top module: `da_fir_serial`

## Requirements
- R1: While reset is held and on the first cycle after it, `busy` and `out_valid` are 0 and `out_y` is 0.
- R2: A sample is taken at a clock edge only when `in_valid` is 1 and `busy` is 0. `busy` is 1 for exactly 16 cycles, starting the cycle after that edge.
- R3: For each accepted sample, `out_valid` is 1 for exactly one cycle. That cycle is the 18th cycle after the acceptance edge, one cycle after `busy` has returned to 0.
- R4: With valid tables, `out_y` is the exact 35-bit two's-complement value of sum over k of C[k]·x[n−k], where tap 0 holds the newest sample x[n].
- R5: Table t (selected by `tbl_sel` = t) at address a holds the sum of the coefficients C[4t+i] for every i where bit i of a is 1. During a bit cycle, address bit i of table t is the current bit of tap 4t+i. A write happens at an edge where `tbl_we` is 1.
- R6: Table writes presented while `busy` is 1 are ignored and change no later output.
- R7: `in_valid` while `busy` is 1 is ignored. The delay line does not move, and later outputs are as if the pulse never happened.
- R8: Reset clears the delay line. The first outputs after reset treat the history as zero.
- R9: The sign bit of each sample is weighted −2^15. Extreme operands are exact: −32768 samples with −32768 coefficients, and 32767 samples with −32768 coefficients.
- R10: `out_y` keeps its value in every cycle in which `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | New sample offered |
| in_sample | input | 16 | Signed input sample |
| busy | output | 1 | Frame in progress; samples and table writes ignored |
| tbl_we | input | 1 | Table write strobe |
| tbl_sel | input | 1 | Table select |
| tbl_addr | input | 4 | Table entry address |
| tbl_wdata | input | 18 | Signed table word |
| out_valid | output | 1 | One-cycle result strobe |
| out_y | output | 35 | Signed filter output |

## Verification
The bench first sends an impulse and then zeros. This gives each coefficient back on its own. A tap-to-address swap would return the wrong coefficient, and a delay line not cleared by reset would add stale terms. Extreme operands are used next. If the sign cycle added the table sum instead of subtracting it, the −32768 results would be off by 2^16 times the sum. If the accumulator were too narrow, the 2^33 product would wrap. Random samples and coefficients then drive the full datapath. Samples offered and table writes made in the middle of a frame, each followed by outputs that depend on the touched state, would show a design that lets either disturb the delay line or the tables.

// File: rtl/da_fir_pkg.sv
package da_fir_pkg;

  localparam int unsigned DA_SAMPLE_W = 16;
  localparam int unsigned DA_COEF_W   = 16;
  localparam int unsigned DA_TAPS     = 8;
  localparam int unsigned DA_GROUP    = 4;

  typedef enum logic [0:0] {
    PH_IDLE  = 1'b0,
    PH_SHIFT = 1'b1
  } da_phase_e;

  function automatic int unsigned sel_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/da_frame_ctrl.sv
module da_frame_ctrl
  import da_fir_pkg::*;
#(
  parameter int unsigned SAMPLE_W = DA_SAMPLE_W
) (
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  output logic accept,
  output logic busy,
  output logic shift_en,
  output logic bit_first,
  output logic bit_last
);

  localparam int unsigned CNT_W = $clog2(SAMPLE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(SAMPLE_W - 1);

  da_phase_e        phase_q;
  logic [CNT_W-1:0] cnt_q;

  always_comb begin
    accept    = in_valid && (phase_q == PH_IDLE);
    busy      = (phase_q == PH_SHIFT);
    shift_en  = (phase_q == PH_SHIFT);
    bit_first = shift_en && (cnt_q == '0);
    bit_last  = shift_en && (cnt_q == LAST_BIT);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      case (phase_q)
        PH_IDLE: begin
          cnt_q <= '0;
          if (accept) phase_q <= PH_SHIFT;
        end
        default: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == LAST_BIT) phase_q <= PH_IDLE;
        end
      endcase
    end
  end

endmodule

// File: rtl/da_tap_line.sv
module da_tap_line
  import da_fir_pkg::*;
#(
  parameter int unsigned SAMPLE_W = DA_SAMPLE_W,
  parameter int unsigned NUM_TAPS = DA_TAPS
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                accept,
  input  logic [SAMPLE_W-1:0] sample,
  input  logic                rotate,
  output logic [NUM_TAPS-1:0] tap_bits
);

  logic [SAMPLE_W-1:0] tap_q [NUM_TAPS];

  for (genvar k = 0; k < NUM_TAPS; k++) begin : g_tap
    logic [SAMPLE_W-1:0] feed;
    if (k == 0) begin : g_head
      assign feed = sample;
    end else begin : g_body
      assign feed = tap_q[k-1];
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        tap_q[k] <= '0;
      end else if (accept) begin
        tap_q[k] <= feed;
      end else if (rotate) begin
        tap_q[k] <= {tap_q[k][0], tap_q[k][SAMPLE_W-1:1]};
      end
    end

    assign tap_bits[k] = tap_q[k][0];
  end

endmodule

// File: rtl/da_coef_table.sv
module da_coef_table
  import da_fir_pkg::*;
#(
  parameter int unsigned ADDR_W = DA_GROUP,
  parameter int unsigned WORD_W = DA_COEF_W + 2
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [WORD_W-1:0] rdata
);

  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/da_shift_acc.sv
module da_shift_acc
  import da_fir_pkg::*;
#(
  parameter int unsigned NUM_TBL  = 2,
  parameter int unsigned ENTRY_W  = DA_COEF_W + 2,
  parameter int unsigned SAMPLE_W = DA_SAMPLE_W,
  parameter int unsigned SUM_W    = ENTRY_W + $clog2(NUM_TBL),
  parameter int unsigned Y_W      = SUM_W + SAMPLE_W
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       step,
  input  logic                       first,
  input  logic                       last,
  input  logic [NUM_TBL*ENTRY_W-1:0] entries,
  output logic                       out_valid,
  output logic [Y_W-1:0]             out_y
);

  logic signed [SUM_W-1:0] tbl_sum;
  logic signed [SUM_W-1:0] hi_q;
  logic [SAMPLE_W-1:0]     lo_q;
  logic signed [SUM_W:0]   base_x;
  logic signed [SUM_W:0]   sum_x;
  logic signed [SUM_W:0]   t_val;

  // Adder tree of all table words, each sign-extended to SUM_W bits.
  always_comb begin
    tbl_sum = '0;
    for (int g = 0; g < NUM_TBL; g++) begin
      tbl_sum = tbl_sum + SUM_W'($signed(entries[g*ENTRY_W +: ENTRY_W]));
    end
  end

  // The first bit starts from zero; the sign bit subtracts its weight.
  always_comb begin
    base_x = first ? '0 : (SUM_W+1)'(hi_q);
    sum_x  = (SUM_W+1)'(tbl_sum);
    t_val  = last ? (base_x - sum_x) : (base_x + sum_x);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q      <= '0;
      lo_q      <= '0;
      out_y     <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= step && last;
      if (step) begin
        hi_q <= t_val[SUM_W:1];
        lo_q <= {t_val[0], lo_q[SAMPLE_W-1:1]};
        if (last) out_y <= {t_val[SUM_W:1], t_val[0], lo_q[SAMPLE_W-1:1]};
      end
    end
  end

endmodule

// File: rtl/da_fir_serial.sv
module da_fir_serial
  import da_fir_pkg::*;
#(
  parameter int unsigned SAMPLE_W = DA_SAMPLE_W,
  parameter int unsigned COEF_W   = DA_COEF_W,
  parameter int unsigned NUM_TAPS = DA_TAPS,
  parameter int unsigned GROUP    = DA_GROUP,
  localparam int unsigned NUM_TBL = NUM_TAPS / GROUP,
  localparam int unsigned SEL_W   = sel_width(NUM_TBL),
  localparam int unsigned ENTRY_W = COEF_W + $clog2(GROUP),
  localparam int unsigned SUM_W   = ENTRY_W + $clog2(NUM_TBL),
  localparam int unsigned Y_W     = SUM_W + SAMPLE_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic [SAMPLE_W-1:0] in_sample,
  output logic                busy,
  input  logic                tbl_we,
  input  logic [SEL_W-1:0]    tbl_sel,
  input  logic [GROUP-1:0]    tbl_addr,
  input  logic [ENTRY_W-1:0]  tbl_wdata,
  output logic                out_valid,
  output logic [Y_W-1:0]      out_y
);

  logic                       accept;
  logic                       shift_en;
  logic                       bit_first;
  logic                       bit_last;
  logic [NUM_TAPS-1:0]        tap_bits;
  logic [NUM_TBL*ENTRY_W-1:0] entries;
  logic                       rd_valid;
  logic                       rd_first;
  logic                       rd_last;

  da_frame_ctrl #(
    .SAMPLE_W (SAMPLE_W)
  ) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .accept    (accept),
    .busy      (busy),
    .shift_en  (shift_en),
    .bit_first (bit_first),
    .bit_last  (bit_last)
  );

  da_tap_line #(
    .SAMPLE_W (SAMPLE_W),
    .NUM_TAPS (NUM_TAPS)
  ) u_taps (
    .clk      (clk),
    .rst      (rst),
    .accept   (accept),
    .sample   (in_sample),
    .rotate   (shift_en),
    .tap_bits (tap_bits)
  );

  for (genvar g = 0; g < NUM_TBL; g++) begin : g_tbl
    logic tbl_wr;
    assign tbl_wr = tbl_we && !busy && (tbl_sel == SEL_W'(g));

    da_coef_table #(
      .ADDR_W (GROUP),
      .WORD_W (ENTRY_W)
    ) u_table (
      .clk   (clk),
      .we    (tbl_wr),
      .waddr (tbl_addr),
      .wdata (tbl_wdata),
      .re    (shift_en),
      .raddr (tap_bits[g*GROUP +: GROUP]),
      .rdata (entries[g*ENTRY_W +: ENTRY_W])
    );
  end

  // Tags that travel alongside the registered table read.
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_first <= 1'b0;
      rd_last  <= 1'b0;
    end else begin
      rd_valid <= shift_en;
      rd_first <= bit_first;
      rd_last  <= bit_last;
    end
  end

  da_shift_acc #(
    .NUM_TBL  (NUM_TBL),
    .ENTRY_W  (ENTRY_W),
    .SAMPLE_W (SAMPLE_W),
    .SUM_W    (SUM_W),
    .Y_W      (Y_W)
  ) u_acc (
    .clk       (clk),
    .rst       (rst),
    .step      (rd_valid),
    .first     (rd_first),
    .last      (rd_last),
    .entries   (entries),
    .out_valid (out_valid),
    .out_y     (out_y)
  );

endmodule

// File: rtl/da_fir_checker.sv
module da_fir_checker #(
  parameter int unsigned SAMPLE_W = 16,
  parameter int unsigned Y_W      = 35
) (
  input logic           clk,
  input logic           rst,
  input logic           in_valid,
  input logic           busy,
  input logic           out_valid,
  input logic [Y_W-1:0] out_y
);

  localparam int unsigned BC_W = $clog2(SAMPLE_W) + 1;

  logic [BC_W-1:0] busy_cnt;

  always_ff @(posedge clk) begin
    if (rst || !busy) busy_cnt <= '0;
    else              busy_cnt <= busy_cnt + 1'b1;
  end

  a_r1_reset_clean: assert property (@(posedge clk)
    rst |=> (!busy && !out_valid && (out_y == '0)));

  a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !busy) |=> busy);

  a_r2_busy_bounded: assert property (@(posedge clk) disable iff (rst)
    busy |-> (busy_cnt < BC_W'(SAMPLE_W)));

  a_r2_busy_length: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> ($past(busy_cnt) == BC_W'(SAMPLE_W - 1)));

  a_r3_single_pulse: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  a_r3_pulse_after_frame: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (!$past(busy) && $past(busy, 2)));

  a_r10_hold_output: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> $stable(out_y));

endmodule

bind da_fir_serial da_fir_checker #(
  .SAMPLE_W (SAMPLE_W),
  .Y_W      (Y_W)
) u_da_fir_checker (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .busy      (busy),
  .out_valid (out_valid),
  .out_y     (out_y)
);

// File: tb/test_da_fir_serial.sv
module test_da_fir_serial;

  localparam int SW = 16;
  localparam int NT = 8;
  localparam int GP = 4;
  localparam int EW = 18;
  localparam int YW = 35;

  logic          clk = 1'b0;
  logic          rst;
  logic          in_valid;
  logic [SW-1:0] in_sample;
  logic          busy;
  logic          tbl_we;
  logic [0:0]    tbl_sel;
  logic [GP-1:0] tbl_addr;
  logic [EW-1:0] tbl_wdata;
  logic          out_valid;
  logic [YW-1:0] out_y;

  int n_checks = 0;
  int n_errs   = 0;
  bit done     = 1'b0;
  int coef [NT];
  int hist [NT];

  always #5 clk = ~clk;

  da_fir_serial i_da_fir_serial (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_sample (in_sample),
    .busy      (busy),
    .tbl_we    (tbl_we),
    .tbl_sel   (tbl_sel),
    .tbl_addr  (tbl_addr),
    .tbl_wdata (tbl_wdata),
    .out_valid (out_valid),
    .out_y     (out_y)
  );

  function automatic longint model_y();
    longint acc = 0;
    for (int k = 0; k < NT; k++) acc += longint'(coef[k]) * longint'(hist[k]);
    return acc;
  endfunction

  function automatic int entry_sum(input int t, input int a);
    int s = 0;
    for (int i = 0; i < GP; i++) if (a[i]) s += coef[GP*t + i];
    return s;
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wrap_up();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", n_checks, n_errs);
      $finish;
    end
  endtask

  task automatic load_tables();
    for (int t = 0; t < NT/GP; t++) begin
      for (int a = 0; a < (1 << GP); a++) begin
        @(negedge clk);
        tbl_we    = 1'b1;
        tbl_sel   = 1'(t);
        tbl_addr  = GP'(a);
        tbl_wdata = EW'(entry_sum(t, a));
      end
    end
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  // disturb: 0 none, 1 sample offered mid-frame, 2 table write mid-frame
  task automatic send(input logic [SW-1:0] x, input int disturb, input string req);
    logic [YW-1:0] y_seen;
    longint exp_y;
    @(negedge clk);
    while (busy) @(negedge clk);
    in_valid  = 1'b1;
    in_sample = x;
    @(negedge clk);
    in_valid = 1'b0;
    for (int k = NT-1; k > 0; k--) hist[k] = hist[k-1];
    hist[0] = int'($signed(x));
    exp_y = model_y();
    check(busy == 1'b1, "R2 busy after accept", longint'(busy), 1);
    for (int c = 2; c <= 16; c++) begin
      @(negedge clk);
      in_valid = 1'b0;
      tbl_we   = 1'b0;
      if (c == 5 && disturb == 1) begin   // R7 stimulus
        in_valid  = 1'b1;
        in_sample = ~x;
      end
      if (c == 5 && disturb == 2) begin   // R6 stimulus
        tbl_we    = 1'b1;
        tbl_sel   = 1'b0;
        tbl_addr  = '1;
        tbl_wdata = 18'h1ABCD;
      end
      check(busy == 1'b1, "R2 busy held", longint'(busy), 1);
    end
    @(negedge clk);
    check(busy == 1'b0, "R2 busy ends after 16", longint'(busy), 0);
    check(out_valid == 1'b0, "R3 no early valid", longint'(out_valid), 0);
    @(negedge clk);
    check(out_valid == 1'b1, "R3 valid pulse", longint'(out_valid), 1);
    check(longint'($signed(out_y)) == exp_y, req, longint'($signed(out_y)), exp_y);
    y_seen = out_y;
    @(negedge clk);
    check(out_valid == 1'b0, "R3 pulse one cycle", longint'(out_valid), 0);
    check(out_y == y_seen, "R10 output held", longint'($signed(out_y)), longint'($signed(y_seen)));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_errs++;
    $display("FAIL watchdog expired");
    wrap_up();
  end

  initial begin
    logic [15:0] r;
    void'($urandom(32'd2718));
    rst = 1'b1; in_valid = 1'b0; in_sample = '0;
    tbl_we = 1'b0; tbl_sel = '0; tbl_addr = '0; tbl_wdata = '0;
    for (int k = 0; k < NT; k++) hist[k] = 0;
    repeat (3) @(negedge clk);
    check(busy == 1'b0 && out_valid == 1'b0 && out_y == '0, "R1 during reset",
          longint'(out_y), 0);
    rst = 1'b0;
    @(negedge clk);
    check(busy == 1'b0 && out_valid == 1'b0 && out_y == '0, "R1 after reset",
          longint'(out_y), 0);

    for (int k = 0; k < NT; k++) begin r = 16'($urandom()); coef[k] = int'($signed(r)); end
    load_tables();

    // impulse: first output against zero history, then each coefficient alone
    send(16'd1, 0, "R8 first output with cleared history");
    for (int k = 1; k < NT; k++) send(16'd0, 0, "R5 tap-to-address mapping");

    for (int n = 0; n < 40; n++) begin
      r = 16'($urandom());
      send(r, 0, "R4 random filtering");
    end

    for (int k = 0; k < NT; k++) coef[k] = -32768;
    load_tables();
    for (int n = 0; n < NT; n++) send(16'h8000, 0, "R9 most negative operands");
    for (int n = 0; n < NT; n++) send(16'h7FFF, 0, "R9 positive max sample");

    for (int k = 0; k < NT; k++) begin r = 16'($urandom()); coef[k] = int'($signed(r)); end
    load_tables();
    for (int n = 0; n < 4; n++) begin
      r = 16'($urandom());
      send(r, 1, "R7 mid-frame sample ignored");
    end
    send(16'hFFFF, 2, "R6 mid-frame table write ignored");
    for (int n = 1; n < NT; n++) send(16'hFFFF, 0, "R6 tables intact");
    for (int n = 0; n < 10; n++) begin
      r = 16'($urandom());
      send(r, 0, "R4 random after reload");
    end

    wrap_up();
  end

endmodule